// File: doc/BRIEF.md
# Paged MDIO Register Bridge

This block gives a host access to 32-bit device registers that sit behind a Clause 22 management bus carrying only 16-bit data. The host issues a read, a write or a masked update with a byte offset. The bridge adds a fixed base to the offset and splits the sum into three fields: a 16-bit page, a 3-bit selector for the PHY address, and a register number. It then runs the whole transaction on the management bus as one unbroken burst of frames.

Each burst starts with a write of the page to a fixed page register at a fixed high PHY address. The register value then moves as two 16-bit halves, with the low half always first. A masked update reads both halves, merges the new bits in, and writes both halves back under the same page selection. The bus is shared with other management masters. The bridge therefore requests the bus before its first frame and keeps it until its last frame is done. The bit-level frame engine, with its own MDC divider, is part of the block.

Top module: `pmdio_bridge`

## Requirements
- R1: The bridge forms the address as BASE_ADDR plus reqOffset. The data PHY address is LO_PREFIX ORed with address bits [7:5]. The low-half register number is the address ANDed with 0x1C, and the page is address bits [23:8].
- R2: Every accepted, valid request starts with a write frame to PHY HI_PREFIX, register PAGE_REG, that carries the page.
- R3: The low half goes to the register number and the high half to the register number with bit 1 set. The low-half frame always comes before the high-half frame.
- R4: reqOp encodes the operation: 0 is read, 1 is write, 2 is masked update. A read returns {high half, low half} on rspRdata. A write returns 0.
- R5: A masked update reads both halves, then writes (old AND NOT reqMask) OR reqWdata, low half first, with no second page write. rspRdata returns the old value.
- R6: An offset above MAX_OFFSET (0x30C), an offset that is not a multiple of 4, or reqOp 3 gives rspErr=1 and rspRdata=0. No frame is sent and busReq is never raised.
- R7: A read half fails when MDIO is high at the second turnaround bit. A failure on the low half skips the high half. A failure in either half of an update skips the write-back. A failure gives rspErr=1 and rspRdata=0.
- R8: busReq rises before the first frame. No frame runs without busGnt. busReq stays high through every frame of the request and falls in the cycle that rspValid is high.
- R9: Frame format: 32 ones, then start 01, then op (01 write, 10 read), the PHY address, the register number, the turnaround (10 driven on writes, released on reads), and 16 data bits MSB first. One MDC period is 2*CLK_DIV clock cycles. MDIO changes only while MDC is low, and read bits are sampled on the rising edge of MDC.
- R10: After reset, reqReady=1 and rspValid=0, busReq=0, mdc=0, mdioOe=0.
- R11: reqReady is low from the cycle after a request is accepted until the response. rspValid is a one-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Bridge idle, request is taken when reqValid is high |
| reqOp | input | 2 | 0 read, 1 write, 2 masked update |
| reqOffset | input | OFS_W | Byte offset of the register |
| reqWdata | input | 32 | Write data, or the OR value for an update |
| reqMask | input | 32 | Bits to clear during an update |
| rspValid | output | 1 | Response pulse |
| rspRdata | output | 32 | Read data, or the old value for an update |
| rspErr | output | 1 | Request failed |
| busReq | output | 1 | Management bus request |
| busGnt | input | 1 | Management bus grant |
| mdc | output | 1 | Management clock |
| mdioOut | output | 1 | MDIO output value |
| mdioOe | output | 1 | MDIO output enable |
| mdioIn | input | 1 | MDIO input value |

## Verification
The assertions assume two things about the environment. First, once busGnt is given it stays high for as long as busReq is high. Second, the host holds reqOffset, reqOp, reqWdata and reqMask stable in the cycle it raises reqValid. The bench's arbiter model grants only after a configurable delay and drops the grant only after busReq falls. The bench drives request fields for a single accepting cycle and changes nothing else on the host side while a request is in flight. The responding device model releases MDIO when it is not driving, and drives it only between falling edges of MDC.

// File: rtl/pmdio_pkg.sv
package pmdio_pkg;
  typedef enum logic [1:0] {OP_READ = 2'd0, OP_WRITE = 2'd1, OP_UPDATE = 2'd2, OP_BAD = 2'd3} op_e;
  typedef enum logic [1:0] {FR_PAGE = 2'd0, FR_LO = 2'd1, FR_HI = 2'd2} frame_e;
  typedef struct packed {
    logic   latchReq;
    logic   startFrame;
    logic   isRead;
    frame_e kind;
    logic   useMerge;
  } strobe_t;
endpackage

// File: rtl/pmdio_datapath.sv
module pmdio_datapath
  import pmdio_pkg::*;
#(
  parameter int          CLK_DIV   = 4,
  parameter int          OFS_W     = 12,
  parameter logic [23:0] BASE_ADDR = 24'h040000,
  parameter logic [4:0]  LO_PREFIX = 5'h10,
  parameter logic [4:0]  HI_PREFIX = 5'h18,
  parameter logic [4:0]  PAGE_REG  = 5'h00
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          st,
  input  logic [OFS_W-1:0] reqOffset,
  input  logic [31:0]      reqWdata,
  input  logic [31:0]      reqMask,
  output logic             frameDone,
  output logic             frameErr,
  output logic [31:0]      rdWord,
  output logic             mdc,
  output logic             mdioOut,
  output logic             mdioOe,
  input  logic             mdioIn
);
  localparam int DIV_W = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
  localparam int IDX_W = 6;

  logic [23:0] addrQ;
  logic [31:0] wdataQ, maskQ, wrWord;
  logic [4:0]  regLo, regHi, dataPhy, fPhy, fReg;
  logic [15:0] fData, shIn;
  logic [63:0] frameQ;
  logic        active, isReadQ;
  frame_e      kindQ;
  logic [IDX_W-1:0] bitIdx;
  logic [DIV_W-1:0] divCnt;
  logic        tick;

  assign regLo   = {addrQ[4:2], 2'b00};
  assign regHi   = regLo | 5'd2;
  assign dataPhy = LO_PREFIX | {2'b00, addrQ[7:5]};
  assign wrWord  = st.useMerge ? ((rdWord & ~maskQ) | wdataQ) : wdataQ;
  assign tick    = active && (divCnt == DIV_W'(CLK_DIV - 1));

  always_comb begin
    case (st.kind)
      FR_PAGE: begin fPhy = HI_PREFIX; fReg = PAGE_REG; fData = addrQ[23:8];    end
      FR_LO:   begin fPhy = dataPhy;   fReg = regLo;    fData = wrWord[15:0];   end
      default: begin fPhy = dataPhy;   fReg = regHi;    fData = wrWord[31:16];  end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ <= '0; wdataQ <= '0; maskQ <= '0;
    end else if (st.latchReq) begin
      addrQ  <= BASE_ADDR + 24'(reqOffset);
      wdataQ <= reqWdata;
      maskQ  <= reqMask;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      active <= 1'b0; bitIdx <= '0; divCnt <= '0; mdc <= 1'b0;
      frameQ <= '0; isReadQ <= 1'b0; kindQ <= FR_PAGE;
      frameErr <= 1'b0; frameDone <= 1'b0; shIn <= '0; rdWord <= '0;
    end else begin
      frameDone <= 1'b0;
      if (st.latchReq) rdWord <= '0;
      if (st.startFrame) begin
        active   <= 1'b1;
        bitIdx   <= '0;
        divCnt   <= '0;
        mdc      <= 1'b0;
        isReadQ  <= st.isRead;
        kindQ    <= st.kind;
        frameErr <= 1'b0;
        shIn     <= '0;
        frameQ   <= {32'hFFFF_FFFF, 2'b01, (st.isRead ? 2'b10 : 2'b01), fPhy, fReg, 2'b10, fData};
      end else if (active) begin
        if (tick) begin
          divCnt <= '0;
          mdc    <= ~mdc;
          if (!mdc) begin
            if (isReadQ && bitIdx == 6'd47) frameErr <= mdioIn;
            if (isReadQ && bitIdx >= 6'd48) shIn <= {shIn[14:0], mdioIn};
          end else if (bitIdx == 6'd63) begin
            active    <= 1'b0;
            frameDone <= 1'b1;
            if (isReadQ && kindQ == FR_LO) rdWord[15:0]  <= shIn;
            if (isReadQ && kindQ == FR_HI) rdWord[31:16] <= shIn;
          end else begin
            bitIdx <= bitIdx + 1'b1;
          end
        end else begin
          divCnt <= divCnt + 1'b1;
        end
      end
    end
  end

  assign mdioOut = active ? frameQ[~bitIdx] : 1'b1;
  assign mdioOe  = active && !(isReadQ && bitIdx >= 6'd46);

  // R9: a driven MDIO value moves only while MDC is low
  assert_mdio_moves_low_R9: assert property (@(posedge clk) disable iff (!rstN)
    (mdioOe && $past(mdioOe) && mdioOut != $past(mdioOut)) |-> !mdc);
  // R3: frames never overlap, so halves keep their order
  assert_no_overlap_R3: assert property (@(posedge clk) disable iff (!rstN)
    st.startFrame |-> !active);
  // R11: completion is a single pulse
  assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rstN)
    frameDone |=> !frameDone);
endmodule

// File: rtl/pmdio_ctrl.sv
module pmdio_ctrl
  import pmdio_pkg::*;
#(
  parameter int OFS_W      = 12,
  parameter int MAX_OFFSET = 'h30C
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  output logic             reqReady,
  input  logic [1:0]       reqOp,
  input  logic [OFS_W-1:0] reqOffset,
  output logic             busReq,
  input  logic             busGnt,
  input  logic             frameDone,
  input  logic             frameErr,
  output strobe_t          st,
  output logic             rspValid,
  output logic             rspErr
);
  typedef enum logic [2:0] {S_IDLE, S_ARB, S_PAGE, S_RLO, S_RHI, S_WLO, S_WHI, S_RESP} state_e;

  state_e state;
  op_e    opQ;
  logic   launched, errQ, badReq, inFrame;

  assign badReq  = (reqOffset > OFS_W'(MAX_OFFSET)) || (reqOffset[1:0] != 2'b00) || (reqOp == 2'd3);
  assign inFrame = state inside {S_PAGE, S_RLO, S_RHI, S_WLO, S_WHI};

  always_comb begin
    st            = '0;
    st.latchReq   = (state == S_IDLE) && reqValid;
    st.startFrame = inFrame && !launched && busGnt;
    st.isRead     = state inside {S_RLO, S_RHI};
    st.useMerge   = (opQ == OP_UPDATE);
    case (state)
      S_RLO, S_WLO: st.kind = FR_LO;
      S_RHI, S_WHI: st.kind = FR_HI;
      default:      st.kind = FR_PAGE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= S_IDLE; opQ <= OP_READ; launched <= 1'b0; errQ <= 1'b0;
    end else begin
      if (st.startFrame) launched <= 1'b1;
      case (state)
        S_IDLE: if (reqValid) begin
          opQ   <= op_e'(reqOp);
          errQ  <= badReq;
          state <= badReq ? S_RESP : S_ARB;
        end
        S_ARB: if (busGnt) state <= S_PAGE;
        S_PAGE: if (frameDone) begin
          launched <= 1'b0;
          state    <= (opQ == OP_WRITE) ? S_WLO : S_RLO;
        end
        S_RLO: if (frameDone) begin
          launched <= 1'b0;
          if (frameErr) begin errQ <= 1'b1; state <= S_RESP; end
          else state <= S_RHI;
        end
        S_RHI: if (frameDone) begin
          launched <= 1'b0;
          if (frameErr) begin errQ <= 1'b1; state <= S_RESP; end
          else state <= (opQ == OP_UPDATE) ? S_WLO : S_RESP;
        end
        S_WLO: if (frameDone) begin launched <= 1'b0; state <= S_WHI; end
        S_WHI: if (frameDone) begin launched <= 1'b0; state <= S_RESP; end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign reqReady = (state == S_IDLE);
  assign busReq   = state inside {S_ARB, S_PAGE, S_RLO, S_RHI, S_WLO, S_WHI};
  assign rspValid = (state == S_RESP);
  assign rspErr   = errQ;

  // R8: the bus is given back exactly when the response goes out
  assert_bus_free_at_rsp_R8: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> !busReq);
  assert_bus_drop_only_rsp_R8: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busReq) |-> rspValid);
  // R6: a rejected request answers at once with an error and no bus request
  assert_bad_req_no_bus_R6: assert property (@(posedge clk) disable iff (!rstN)
    (reqReady && reqValid && badReq) |=> (rspValid && rspErr && !busReq));
  // R11: single-cycle response
  assert_rsp_pulse_R11: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |=> !rspValid);
endmodule

// File: rtl/pmdio_bridge.sv
module pmdio_bridge
  import pmdio_pkg::*;
#(
  parameter int          CLK_DIV    = 4,
  parameter int          OFS_W      = 12,
  parameter int          MAX_OFFSET = 'h30C,
  parameter logic [23:0] BASE_ADDR  = 24'h040000,
  parameter logic [4:0]  LO_PREFIX  = 5'h10,
  parameter logic [4:0]  HI_PREFIX  = 5'h18,
  parameter logic [4:0]  PAGE_REG   = 5'h00
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  output logic             reqReady,
  input  logic [1:0]       reqOp,
  input  logic [OFS_W-1:0] reqOffset,
  input  logic [31:0]      reqWdata,
  input  logic [31:0]      reqMask,
  output logic             rspValid,
  output logic [31:0]      rspRdata,
  output logic             rspErr,
  output logic             busReq,
  input  logic             busGnt,
  output logic             mdc,
  output logic             mdioOut,
  output logic             mdioOe,
  input  logic             mdioIn
);
  strobe_t     st;
  logic        frameDone, frameErr;
  logic [31:0] rdWord;

  pmdio_ctrl #(.OFS_W(OFS_W), .MAX_OFFSET(MAX_OFFSET)) u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqOp(reqOp), .reqOffset(reqOffset), .busReq(busReq), .busGnt(busGnt),
    .frameDone(frameDone), .frameErr(frameErr), .st(st),
    .rspValid(rspValid), .rspErr(rspErr)
  );

  pmdio_datapath #(
    .CLK_DIV(CLK_DIV), .OFS_W(OFS_W), .BASE_ADDR(BASE_ADDR),
    .LO_PREFIX(LO_PREFIX), .HI_PREFIX(HI_PREFIX), .PAGE_REG(PAGE_REG)
  ) u_dp (
    .clk(clk), .rstN(rstN), .st(st), .reqOffset(reqOffset),
    .reqWdata(reqWdata), .reqMask(reqMask), .frameDone(frameDone),
    .frameErr(frameErr), .rdWord(rdWord), .mdc(mdc), .mdioOut(mdioOut),
    .mdioOe(mdioOe), .mdioIn(mdioIn)
  );

  assign rspRdata = rspErr ? 32'h0 : rdWord;
endmodule

// File: tb/pmdio_bridge_bench.sv
module pmdio_bridge_bench;
  localparam int          CLK_PERIOD = 10;
  localparam int          CLK_DIV    = 3;
  localparam logic [23:0] BASE       = 24'h040000;
  localparam logic [4:0]  LO         = 5'h10;
  localparam logic [4:0]  HI         = 5'h18;
  localparam logic [4:0]  PREG       = 5'h00;

  logic clk = 1'b0, rstN = 1'b0;
  logic reqValid = 1'b0, reqReady, rspValid, rspErr, busReq, busGnt = 1'b0;
  logic [1:0]  reqOp = 2'd0;
  logic [11:0] reqOffset = '0;
  logic [31:0] reqWdata = '0, reqMask = '0, rspRdata;
  logic mdc, mdioOut, mdioOe, mdioIn = 1'b1;

  int nChecks = 0, nFail = 0, rspCount = 0, gntDelay = 2, gntCnt = 0;
  bit finished = 0, busSeen = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pmdio_bridge #(.CLK_DIV(CLK_DIV), .BASE_ADDR(BASE), .LO_PREFIX(LO),
                 .HI_PREFIX(HI), .PAGE_REG(PREG)) u_pmdio_bridge (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqOp(reqOp), .reqOffset(reqOffset), .reqWdata(reqWdata), .reqMask(reqMask),
    .rspValid(rspValid), .rspRdata(rspRdata), .rspErr(rspErr),
    .busReq(busReq), .busGnt(busGnt), .mdc(mdc), .mdioOut(mdioOut),
    .mdioOe(mdioOe), .mdioIn(mdioIn)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // arbiter model: grant after gntDelay cycles, released when request drops
  always @(posedge clk) begin
    if (!busReq) begin busGnt <= 1'b0; gntCnt <= 0; end
    else if (gntCnt < gntDelay) gntCnt <= gntCnt + 1;
    else busGnt <= 1'b1;
  end
  always @(negedge clk) if (busReq) busSeen = 1;

  // register model behind the bus
  logic [15:0] mem [bit [25:0]];
  logic [15:0] curPage = 16'h0;
  bit failEn = 0;
  logic [4:0] failPhy = 5'h0, failReg = 5'h0;

  function automatic logic [15:0] memRd(input logic [25:0] k);
    if (mem.exists(k)) return mem[k];
    return k[15:0] ^ 16'h5A3C;
  endfunction

  typedef struct packed {logic rd; logic [4:0] phy; logic [4:0] rg; logic [15:0] data;} frm_t;
  frm_t  expFrames[$];
  string expFrameTag[$];
  logic [31:0] expRdQ[$];
  logic  expErrQ[$];
  logic  expBadQ[$];
  string expTagQ[$];

  task automatic pushF(input logic rd, input logic [4:0] ph, input logic [4:0] rg,
                       input logic [15:0] d, input string tag);
    expFrames.push_back({rd, ph, rg, d});
    expFrameTag.push_back(tag);
  endtask

  // slave side of the management bus
  int pos = -1, onesCnt = 0;
  logic [63:0] cap = '0;
  logic isRd = 1'b0, noAck = 1'b0, nextDrv = 1'b1, gntOk = 1'b1;
  logic [15:0] rdVal = '0;
  longint lastRise = 0;

  always @(posedge mdc) begin
    longint now;
    now = $time;
    if (pos < 0) begin
      if (mdioOut) onesCnt++;
      else begin
        chk(onesCnt == 32, "R9 preamble length", onesCnt, 32);
        cap = '1; cap[31] = 1'b0; pos = 33; isRd = 1'b0; gntOk = busGnt;
      end
    end else begin
      if (!busGnt) gntOk = 1'b0;
      if (!(isRd && pos >= 46)) cap[63-pos] = mdioOut;
      if (pos == 35) isRd = (cap[29:28] == 2'b10);
      if (pos == 40) chk(now - lastRise == longint'(2*CLK_DIV*CLK_PERIOD), "R9 mdc period",
                         now - lastRise, 2*CLK_DIV*CLK_PERIOD);
      if (pos == 45) begin
        noAck = isRd && failEn && cap[27:23] == failPhy && cap[22:18] == failReg;
        rdVal = memRd({curPage, cap[27:23], cap[22:18]});
      end
      if (pos == 46 && isRd) chk(!mdioOe, "R9 turnaround released on read", mdioOe, 0);
      if (pos >= 46 && pos < 63 && isRd) nextDrv = noAck ? 1'b1 : (pos == 46 ? 1'b0 : rdVal[62-pos]);
      else nextDrv = 1'b1;
      if (pos == 63) begin
        frm_t f;
        string t;
        chk(cap[31:30] == 2'b01 && (cap[29:28] == 2'b01 || cap[29:28] == 2'b10),
            "R9 start and opcode", cap[31:28], 4'b0101);
        if (!isRd) chk(cap[17:16] == 2'b10, "R9 write turnaround", cap[17:16], 2'b10);
        chk(gntOk, "R8 grant held during frame", gntOk, 1);
        if (expFrames.size() == 0) chk(0, "R2 unexpected frame", cap[27:0], 0);
        else begin
          f = expFrames.pop_front();
          t = expFrameTag.pop_front();
          chk(isRd == f.rd && cap[27:23] == f.phy && cap[22:18] == f.rg, t,
              {isRd, cap[27:18]}, {f.rd, f.phy, f.rg});
          if (!isRd) chk(cap[15:0] == f.data, t, cap[15:0], f.data);
        end
        if (!isRd) begin
          if (cap[27:23] == HI && cap[22:18] == PREG) curPage = cap[15:0];
          else mem[{curPage, cap[27:23], cap[22:18]}] = cap[15:0];
        end
        pos = -1; onesCnt = 0;
      end else pos++;
    end
    lastRise = now;
  end

  always @(negedge mdc) mdioIn <= nextDrv;

  // response monitor (scoreboard)
  always @(negedge clk) begin
    if (rspValid && rstN) begin
      if (expRdQ.size() == 0) chk(0, "R11 unexpected response", rspRdata, 0);
      else begin
        logic [31:0] er; logic ee, eb; string t;
        er = expRdQ.pop_front(); ee = expErrQ.pop_front();
        eb = expBadQ.pop_front(); t = expTagQ.pop_front();
        chk(rspRdata == er, {t, " rdata"}, rspRdata, er);
        chk(rspErr == ee, {t, " err"}, rspErr, ee);
        chk(!busReq, "R8 bus released with response", busReq, 0);
        chk(expFrames.size() == 0, "R7 frames outstanding at response", expFrames.size(), 0);
        if (eb) chk(!busSeen, "R6 no bus request on rejected access", busSeen, 0);
      end
      rspCount++;
    end
  end

  task automatic doReq(input logic [1:0] op, input logic [11:0] ofs, input logic [31:0] wd,
                       input logic [31:0] mk, input string tag);
    logic [23:0] a; logic [15:0] pg; logic [4:0] ph, rl, rh;
    logic bad, loFail, hiFail, expErr; logic [31:0] old, newv, expRd;
    int c0;
    a  = BASE + {12'h0, ofs};
    pg = a[23:8]; ph = LO | {2'b00, a[7:5]}; rl = {a[4:2], 2'b00}; rh = rl | 5'd2;
    bad = (ofs > 12'h30C) || (ofs[1:0] != 2'b00) || (op == 2'd3);
    old = {memRd({pg, ph, rh}), memRd({pg, ph, rl})};
    loFail = failEn && failPhy == ph && failReg == rl;
    hiFail = failEn && failPhy == ph && failReg == rh;
    expErr = 1'b0; expRd = 32'h0;
    if (bad) expErr = 1'b1;
    else begin
      pushF(1'b0, HI, PREG, pg, "R2 page write");
      if (op == 2'd1) begin
        pushF(1'b0, ph, rl, wd[15:0], "R1 R3 write low half");
        pushF(1'b0, ph, rh, wd[31:16], "R3 write high half");
      end else begin
        pushF(1'b1, ph, rl, old[15:0], "R1 R3 read low half");
        if (loFail) expErr = 1'b1;
        else begin
          pushF(1'b1, ph, rh, old[31:16], "R3 read high half");
          if (hiFail) expErr = 1'b1;
          else if (op == 2'd2) begin
            newv = (old & ~mk) | wd;
            pushF(1'b0, ph, rl, newv[15:0], "R5 merged low half");
            pushF(1'b0, ph, rh, newv[31:16], "R5 merged high half");
          end
        end
        if (!expErr) expRd = old;
      end
    end
    expRdQ.push_back(expRd); expErrQ.push_back(expErr);
    expBadQ.push_back(bad); expTagQ.push_back(tag);
    @(negedge clk);
    while (!reqReady) @(negedge clk);
    busSeen = 0;
    c0 = rspCount;
    reqOp = op; reqOffset = ofs; reqWdata = wd; reqMask = mk; reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    chk(!reqReady, "R11 ready low after accept", reqReady, 0);
    while (rspCount == c0) @(negedge clk);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk(reqReady && !rspValid && !busReq && !mdc && !mdioOe, "R10 reset state",
        {reqReady, rspValid, busReq, mdc, mdioOe}, 5'b10000);
    doReq(2'd1, 12'h000, 32'h1234_5678, 32'h0, "R4 write");
    doReq(2'd0, 12'h000, 32'h0, 32'h0, "R4 read back");
    doReq(2'd0, 12'h30C, 32'h0, 32'h0, "R1 R4 read top offset");
    gntDelay = 7;
    doReq(2'd1, 12'h0E4, 32'hDEAD_BEEF, 32'h0, "R1 R8 write with slow grant");
    gntDelay = 0;
    doReq(2'd2, 12'h0E4, 32'h0000_AB00, 32'h0000_FF00, "R5 update");
    doReq(2'd0, 12'h0E4, 32'h0, 32'h0, "R5 read merged");
    doReq(2'd2, 12'h208, 32'hF000_000F, 32'hFFFF_FFFF, "R5 update full mask");
    doReq(2'd0, 12'h310, 32'h0, 32'h0, "R6 offset above top");
    doReq(2'd1, 12'h002, 32'h1, 32'h0, "R6 misaligned");
    doReq(2'd3, 12'h010, 32'h0, 32'h0, "R6 invalid op");
    failEn = 1; failPhy = LO | 5'd0; failReg = 5'h00;
    doReq(2'd0, 12'h100, 32'h0, 32'h0, "R7 low half no ack");
    failPhy = LO | 5'd7; failReg = 5'h06;
    doReq(2'd2, 12'h0E4, 32'hFFFF_0000, 32'hFFFF_FFFF, "R7 update high half no ack");
    failEn = 0;
    doReq(2'd0, 12'h0E4, 32'h0, 32'h0, "R7 value kept after failed update");
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nChecks++; nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
      $finish;
    end
  end
endmodule